// File: doc/BRIEF.md
# Three-Level Burst Waveform Generator

This block produces the two control bits that steer one channel of a three-level half-bridge pulser stage. The stage can drive the output positive, drive it negative, or clamp it to ground. The generator also drives a flag that chooses between the pulsed output stage and the continuous-wave output stage. Timing is set in clock cycles. The settings are the half period, the number of half periods in a burst, which polarity comes first, and the repetition interval.

In pulsed mode the block sends a burst of alternating half periods. It then clamps the output to ground until the repetition interval expires, and after that it starts the burst again. An optional second segment follows the first one directly. The second segment has its own half period and its own count, which allows bursts such as 1.5 cycles at a slow rate followed by 5 cycles at a fast rate. Counts are given in half periods, so an odd count gives a half-pulse ending. In continuous-wave mode the output alternates until a stop arrives. In this mode the block ignores the counts and the interval.

The settings are captured when a start is accepted from idle. A stop returns the channel to ground. The analog stage is outside this block.

Top module: `burst_pulser`

## Requirements
- R1: While reset is low, and after reset until the first start, level_o is 00 and cw_sel_o is 0.
- R2: level_o uses 00 for the ground clamp, 01 for the positive level and 10 for the negative level. The value 11 never appears.
- R3: When start_i is high in idle and stop_i is low, the first half period appears in the next cycle. It is negative when neg_first_i is 1 and positive otherwise.
- R4: Each half period of a segment lasts exactly that segment's half-period count of cycles. The polarity inverts at every half-period boundary.
- R5: A segment ends after its count of half periods. An odd count therefore ends on the starting polarity. When no further segment follows, level_o holds 00.
- R6: In pulsed mode a new burst begins every pri_i cycles, measured from the previous burst start, with the first polarity restored. If the interval is shorter than the burst, the burst is cut at that point.
- R7: When seg1_en_i is set, the second segment follows the first one with no gap. It uses seg1_half_i and seg1_cnt_i, and the polarity alternation continues across the boundary.
- R8: In continuous-wave mode the output alternates with the first segment's half period without pause, ignoring counts and interval, and cw_sel_o is 1 while it runs.
- R9: stop_i forces level_o to 00 and cw_sel_o to 0 from the next cycle. It wins over a start in the same cycle.
- R10: A start while running has no effect. Changes to the configuration inputs after an accepted start do not alter the running waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, accepted only from idle |
| stop_i | input | 1 | Return to idle and ground |
| cw_i | input | 1 | Continuous-wave mode select |
| neg_first_i | input | 1 | First half period negative when 1 |
| seg0_half_i | input | HALF_W | First segment half period in cycles (at least 1) |
| seg0_cnt_i | input | CNT_W | First segment half-period count (at least 1) |
| seg1_en_i | input | 1 | Enable second segment |
| seg1_half_i | input | HALF_W | Second segment half period in cycles (at least 1) |
| seg1_cnt_i | input | CNT_W | Second segment half-period count (at least 1) |
| pri_i | input | PRI_W | Repetition interval in cycles (at least 1) |
| level_o | output | 2 | Level code to the half-bridge |
| cw_sel_o | output | 1 | Selects the continuous-wave output stage |

## Verification
Two collisions matter most. The first is the end of the repetition interval landing on the same cycle as a segment end or a half-period boundary. The bench provokes it with an interval equal to the burst length and with an interval shorter than the burst, and the new burst must win, starting on the first polarity. The second is a stop and a start in the same cycle, both from idle and while running, where the channel must stay at or return to ground. A behavioural model computes the expected level from the elapsed cycle count modulo the interval. It is compared with both outputs on every clock.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SEG0, PH_SEG1, PH_GAP} phase_e;

  localparam logic [1:0] LVL_GND = 2'b00;
  localparam logic [1:0] LVL_POS = 2'b01;
  localparam logic [1:0] LVL_NEG = 2'b10;

  function automatic logic [1:0] drive_code(input logic active, input logic neg);
    if (!active) return LVL_GND;
    return neg ? LVL_NEG : LVL_POS;
  endfunction
endpackage

// File: rtl/burst_cycle_counter.sv
module burst_cycle_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         last_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == limit_i - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/burst_pulser.sv
module burst_pulser
  import burst_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int CNT_W  = 8,
  parameter int PRI_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              cw_i,
  input  logic              neg_first_i,
  input  logic [HALF_W-1:0] seg0_half_i,
  input  logic [CNT_W-1:0]  seg0_cnt_i,
  input  logic              seg1_en_i,
  input  logic [HALF_W-1:0] seg1_half_i,
  input  logic [CNT_W-1:0]  seg1_cnt_i,
  input  logic [PRI_W-1:0]  pri_i,
  output logic [1:0]        level_o,
  output logic              cw_sel_o
);
  phase_e            state_q, state_d;
  logic              pol_q;
  logic              cfg_cw_q, cfg_neg_q, cfg_s1_q;
  logic [HALF_W-1:0] cfg_h0_q, cfg_h1_q;
  logic [CNT_W-1:0]  cfg_n0_q, cfg_n1_q;
  logic [PRI_W-1:0]  cfg_pri_q;

  logic              running, in_seg, launch, clr_all;
  logic              half_last, cnt_last, pri_last, seg_end;
  logic [HALF_W-1:0] cur_half;
  logic [CNT_W-1:0]  cur_cnt;

  assign running  = (state_q != PH_IDLE);
  assign in_seg   = (state_q == PH_SEG0) || (state_q == PH_SEG1);
  assign launch   = (state_q == PH_IDLE) && start_i && !stop_i;
  assign clr_all  = (state_q == PH_IDLE) || stop_i || pri_last;
  assign cur_half = (state_q == PH_SEG1) ? cfg_h1_q : cfg_h0_q;
  assign cur_cnt  = (state_q == PH_SEG1) ? cfg_n1_q : cfg_n0_q;
  assign seg_end  = cnt_last && !cfg_cw_q;

  // cycles within a half period
  burst_cycle_counter #(.W(HALF_W)) u_half (
    .clk_i, .rst_ni, .clr_i(clr_all), .run_i(in_seg),
    .limit_i(cur_half), .last_o(half_last)
  );

  // half periods within a segment
  burst_cycle_counter #(.W(CNT_W)) u_count (
    .clk_i, .rst_ni, .clr_i(clr_all), .run_i(half_last),
    .limit_i(cur_cnt), .last_o(cnt_last)
  );

  // repetition interval, idle in continuous-wave mode
  burst_cycle_counter #(.W(PRI_W)) u_pri (
    .clk_i, .rst_ni, .clr_i(state_q == PH_IDLE || stop_i), .run_i(running && !cfg_cw_q),
    .limit_i(cfg_pri_q), .last_o(pri_last)
  );

  always_comb begin
    state_d = state_q;
    if (stop_i)             state_d = PH_IDLE;
    else if (launch)        state_d = PH_SEG0;
    else if (pri_last)      state_d = PH_SEG0;
    else if (seg_end) begin
      if (state_q == PH_SEG0 && cfg_s1_q) state_d = PH_SEG1;
      else                                state_d = PH_GAP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PH_IDLE;
      pol_q     <= 1'b0;
      cfg_cw_q  <= 1'b0;
      cfg_neg_q <= 1'b0;
      cfg_s1_q  <= 1'b0;
      cfg_h0_q  <= '0;
      cfg_h1_q  <= '0;
      cfg_n0_q  <= '0;
      cfg_n1_q  <= '0;
      cfg_pri_q <= '0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        pol_q     <= neg_first_i;
        cfg_cw_q  <= cw_i;
        cfg_neg_q <= neg_first_i;
        cfg_s1_q  <= seg1_en_i;
        cfg_h0_q  <= seg0_half_i;
        cfg_h1_q  <= seg1_half_i;
        cfg_n0_q  <= seg0_cnt_i;
        cfg_n1_q  <= seg1_cnt_i;
        cfg_pri_q <= pri_i;
      end else if (pri_last) begin
        pol_q <= cfg_neg_q;
      end else if (half_last) begin
        pol_q <= ~pol_q;
      end
    end
  end

  assign level_o  = drive_code(in_seg, pol_q);
  assign cw_sel_o = running && cfg_cw_q;

  assert_never_11_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o != 2'b11);

  assert_launch_polarity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> level_o == ($past(neg_first_i) ? LVL_NEG : LVL_POS));

  assert_half_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_last && !seg_end && !pri_last && !stop_i) |=> level_o != $past(level_o));

  assert_half_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_seg && !half_last && !pri_last && !stop_i) |=> $stable(level_o));

  assert_tail_ground_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_end && !pri_last && !stop_i && (state_q == PH_SEG1 || !cfg_s1_q)) |=> level_o == LVL_GND);

  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_last && !stop_i) |=> level_o == (cfg_neg_q ? LVL_NEG : LVL_POS));

  assert_cw_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_sel_o |-> level_o != LVL_GND);

  assert_stop_ground_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (level_o == LVL_GND && !cw_sel_o));
endmodule

// File: tb/tb_burst_pulser.sv
module tb_burst_pulser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0, cw = 1'b0, negf = 1'b0, s1en = 1'b0;
  logic [15:0] h0 = 16'd1, h1 = 16'd1, pri = 16'd1;
  logic [7:0]  n0 = 8'd1, n1 = 8'd1;
  logic [1:0]  level;
  logic        cw_sel;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  // model state
  bit m_run = 1'b0;
  int m_t = 0, m_h0 = 1, m_n0 = 1, m_h1 = 1, m_n1 = 1, m_pri = 1;
  bit m_cw = 1'b0, m_neg = 1'b0, m_s1 = 1'b0;

  always #4 clk = ~clk;

  burst_pulser dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .cw_i(cw),
    .neg_first_i(negf), .seg0_half_i(h0), .seg0_cnt_i(n0), .seg1_en_i(s1en),
    .seg1_half_i(h1), .seg1_cnt_i(n1), .pri_i(pri), .level_o(level), .cw_sel_o(cw_sel)
  );

  function automatic logic [1:0] ref_level(int t);
    int r, b0, idx;
    if (m_cw) begin
      idx = t / m_h0;
    end else begin
      r  = t % m_pri;
      b0 = m_h0 * m_n0;
      if (r < b0) idx = r / m_h0;
      else if (m_s1 && r < b0 + m_h1 * m_n1) idx = m_n0 + (r - b0) / m_h1;
      else return 2'b00;
    end
    return (m_neg ^ idx[0]) ? 2'b10 : 2'b01;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_run <= 1'b0;
    else if (stop) m_run <= 1'b0;
    else if (!m_run && start) begin
      m_run <= 1'b1; m_t <= 0;
      m_cw <= cw; m_neg <= negf; m_s1 <= s1en;
      m_h0 <= int'(h0); m_n0 <= int'(n0); m_h1 <= int'(h1); m_n1 <= int'(n1); m_pri <= int'(pri);
    end else if (m_run) m_t <= m_t + 1;
  end

  always @(negedge clk) begin
    logic [1:0] el;
    logic ec;
    if (!done) begin
      el = m_run ? ref_level(m_t) : 2'b00;
      ec = m_run && m_cw;
      checks++;
      if (level !== el || cw_sel !== ec) begin
        errors++;
        $display("FAIL %s t=%0d level=%b cw_sel=%b expected level=%b cw_sel=%b",
                 tag, m_t, level, cw_sel, el, ec);
      end
    end
  end

  task automatic launch(input bit c, input bit ng, input int a0, input int c0,
                        input bit e1, input int a1, input int c1, input int p);
    cw = c; negf = ng; h0 = 16'(a0); n0 = 8'(c0); s1en = e1;
    h1 = 16'(a1); n1 = 8'(c1); pri = 16'(p); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // scramble inputs: captured config must hold (R10)
    cw = ~c; negf = ~ng; h0 = 16'd7; n0 = 8'd2; s1en = ~e1; pri = 16'd13;
  endtask

  task automatic halt();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    tag = "R2_R4_R5_R6";
    launch(1'b0, 1'b0, 2, 10, 1'b0, 1, 1, 40);
    repeat (30) @(negedge clk);
    tag = "R10";
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (70) @(negedge clk);
    tag = "R9";
    halt();

    tag = "R3_R5_odd";
    launch(1'b0, 1'b1, 1, 3, 1'b0, 1, 1, 20);
    repeat (60) @(negedge clk);
    halt();

    tag = "R7";
    launch(1'b0, 1'b0, 4, 3, 1'b1, 2, 10, 60);
    repeat (150) @(negedge clk);
    halt();

    tag = "R6_truncate";
    launch(1'b0, 1'b1, 3, 10, 1'b0, 1, 1, 20);
    repeat (70) @(negedge clk);
    halt();

    tag = "R6_exact";
    launch(1'b0, 1'b0, 2, 4, 1'b1, 1, 1, 9);
    repeat (50) @(negedge clk);
    halt();

    tag = "R8";
    launch(1'b1, 1'b1, 3, 2, 1'b0, 1, 1, 5);
    repeat (60) @(negedge clk);

    tag = "R9_stop_start";
    stop = 1'b1; start = 1'b1; @(negedge clk);
    stop = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    cw = 1'b0; negf = 1'b0; h0 = 16'd2; n0 = 8'd4; pri = 16'd30;
    stop = 1'b1; start = 1'b1; @(negedge clk);
    stop = 1'b0; start = 1'b0;
    repeat (5) @(negedge clk);

    tag = "R8_min";
    launch(1'b1, 1'b0, 1, 1, 1'b0, 1, 1, 1);
    repeat (20) @(negedge clk);
    halt();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule